// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a two-wire serial slave that gives a host controller access to a small bank of 8-bit control registers. It watches the SCL and SDA lines through synchronizers and finds start and stop conditions. It shifts bytes in and out with the most significant bit first, and it answers on the bus only through an open-drain pull-down enable. Every register is also driven out in parallel, so that neighbouring logic can use the settings.

Each transaction opens with the device address. The command byte then selects one of two kinds of access. An indexed access moves a single register. A block access always begins at register zero: on a write it carries a byte count, and on a read it returns a byte count. Reads use a repeated start followed by the read form of the address. The registers take fixed defaults at reset. The highest register holds an identification value and cannot be changed.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) and 0xD3 (read), that is, 7-bit address 0x69. It leaves SDA released for any other address until the next start condition.
- R2: In the command byte, bit 7 = 1 selects an indexed single-byte access and bit 7 = 0 selects a block access. Bits 6:5 must be 00, or the command byte is not acknowledged. Every later byte of that transaction is then not acknowledged and changes no register.
- R3: An indexed write stores its data byte in the register that command bits 4:0 select. A command whose index is 8 or more is not acknowledged. A second data byte in the same transaction is not acknowledged and is not stored.
- R4: An indexed read returns the selected register, most significant bit first. The read begins with the write address and the command byte, then a repeated start and the read address.
- R5: In a block write, the slave acknowledges the byte count. The data bytes that follow go to registers 0, 1, 2 and so on, in ascending order. A data byte beyond the last register is not acknowledged.
- R6: A block read first returns the value 8, then registers 0 to 7 in ascending order. After the host's NACK, the slave leaves SDA released.
- R7: After reset, registers 0 and 1 hold 0xFF, register 7 holds 0x18 and the others hold 0x00. Register i is driven on regs_o bits [8i+7:8i].
- R8: Register 7 is read-only. A write to it is acknowledged and has no effect.
- R9: A read address is acknowledged only when an accepted command byte has been seen since the last stop condition. A stop condition discards that command.
- R10: The slave changes its SDA pull-down only while SCL is low, given that each SCL low phase lasts longer than the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired level) |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NREG*8 | Parallel copy of all registers, register i in byte lane i |

## Verification
The bench builds the block with its default parameters: eight registers, the identification value 0x18 and two synchronizer stages. With eight registers, command index 8 still fits in the 5-bit index field. The bench can therefore reach the rejected out-of-range index. It can also reach the block-write overrun on the ninth data byte, and the full block read of a count byte plus eight registers. The master model holds each SCL phase for eight system clocks, which is longer than the synchronizer latency. This lets the bench check the SDA ownership rule at the bus level as well.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } smb_phase_e;

  // power-up value of register idx in a bank of nreg registers
  function automatic logic [7:0] reg_default(input int idx, input int nreg,
                                             input logic [7:0] id);
    if (idx == nreg - 1) return id;
    if (idx < 2) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic cmd_single(input logic [7:0] c);
    return c[7];
  endfunction

  function automatic logic cmd_cs_ok(input logic [7:0] c);
    return c[6:5] == 2'b00;
  endfunction

  function automatic logic [4:0] cmd_index(input logic [7:0] c);
    return c[4:0];
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= {STAGES{1'b1}};
      sda_pipe <= {STAGES{1'b1}};
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_store.sv
module smb_reg_store
  import smb_regbank_pkg::*;
#(
  parameter int          NREG     = 8,
  parameter logic [7:0]  ID_VALUE = 8'h18,
  localparam int         IW       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (gi == NREG - 1) begin : g_id
      assign regs_flat[gi*8 +: 8] = ID_VALUE;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               q <= reg_default(gi, NREG, ID_VALUE);
        else if (wr_en && wr_idx == IW'(gi))      q <= wr_data;
      end
      assign regs_flat[gi*8 +: 8] = q;
    end
  end

  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != IW'(NREG - 1)) |=> regs_flat[$past(wr_idx)*8 +: 8] == $past(wr_data));

  // R8
  id_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(NREG - 1)) |=> $stable(regs_flat));
endmodule

// File: rtl/smb_xact_fsm.sv
module smb_xact_fsm
  import smb_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  localparam int        IW       = $clog2(NREG),
  localparam int        PW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [NREG*8-1:0] regs_flat,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_pull
);
  smb_phase_e  phase_q, nxt_phase;
  logic [3:0]  bitcnt_q;
  logic        in_ack_q, ack_drive_q, mack_q, rd_first_q;
  logic        cmd_valid_q, blk_q;
  logic [4:0]  off_q;
  logic [PW-1:0] ptr_q, rd_k_q;
  logic [7:0]  rx_q, tx_q;
  logic        accept;
  logic        byte_end;
  logic        ptr_ok;

  // byte the slave sends as item k of a read burst
  function automatic logic [7:0] pick_tx(input logic blk, input logic [PW-1:0] k,
                                         input logic [4:0] off,
                                         input logic [NREG*8-1:0] r);
    if (blk) begin
      if (k == '0) return 8'(NREG);
      if (int'(k) - 1 < NREG) return r[(int'(k) - 1)*8 +: 8];
      return 8'hFF;
    end
    if (k == '0) return r[int'(off)*8 +: 8];
    return 8'hFF;
  endfunction

  assign byte_end = scl_fall && !in_ack_q && bitcnt_q == 4'd8;
  assign ptr_ok   = ptr_q < PW'(NREG);

  always_comb begin
    accept    = 1'b0;
    nxt_phase = PH_IGNORE;
    unique case (phase_q)
      PH_ADDR: begin
        if (addr_hit(rx_q, DEV_ADDR)) begin
          if (!rx_q[0]) begin
            accept = 1'b1; nxt_phase = PH_CMD;
          end else if (cmd_valid_q) begin
            accept = 1'b1; nxt_phase = PH_RDATA;
          end
        end
      end
      PH_CMD: begin
        if (cmd_cs_ok(rx_q) &&
            (!cmd_single(rx_q) || {1'b0, cmd_index(rx_q)} < PW'(NREG))) begin
          accept    = 1'b1;
          nxt_phase = cmd_single(rx_q) ? PH_WDATA : PH_COUNT;
        end
      end
      PH_COUNT: begin
        accept = 1'b1; nxt_phase = PH_WDATA;
      end
      PH_WDATA: begin
        if (ptr_ok) begin
          accept = 1'b1; nxt_phase = PH_WDATA;
        end
      end
      default: begin
        accept = 1'b0; nxt_phase = phase_q;
      end
    endcase
  end

  assign wr_en   = byte_end && phase_q == PH_WDATA && ptr_ok;
  assign wr_idx  = ptr_q[IW-1:0];
  assign wr_data = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bitcnt_q    <= '0;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
      mack_q      <= 1'b0;
      rd_first_q  <= 1'b0;
      cmd_valid_q <= 1'b0;
      blk_q       <= 1'b0;
      off_q       <= '0;
      ptr_q       <= '0;
      rd_k_q      <= '0;
      rx_q        <= '0;
      tx_q        <= 8'hFF;
    end else if (stop_evt) begin
      phase_q     <= PH_IDLE;
      cmd_valid_q <= 1'b0;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
      bitcnt_q    <= '0;
    end else if (start_evt) begin
      phase_q     <= PH_ADDR;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
      bitcnt_q    <= '0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (in_ack_q) mack_q <= ~sda_s;
        else if (bitcnt_q < 4'd8) begin
          rx_q     <= {rx_q[6:0], sda_s};
          bitcnt_q <= bitcnt_q + 4'd1;
        end
      end else if (scl_fall) begin
        if (in_ack_q) begin
          in_ack_q    <= 1'b0;
          ack_drive_q <= 1'b0;
          bitcnt_q    <= '0;
          if (phase_q == PH_RDATA) begin
            if (rd_first_q || mack_q) begin
              tx_q       <= pick_tx(blk_q, rd_k_q, off_q, regs_flat);
              rd_k_q     <= (rd_k_q == '1) ? rd_k_q : rd_k_q + 1'b1;
              rd_first_q <= 1'b0;
            end else begin
              phase_q <= PH_IGNORE;
            end
          end
        end else if (bitcnt_q == 4'd8) begin
          in_ack_q    <= 1'b1;
          ack_drive_q <= accept;
          phase_q     <= nxt_phase;
          if (phase_q == PH_ADDR && nxt_phase == PH_RDATA) begin
            rd_first_q <= 1'b1;
            rd_k_q     <= '0;
          end
          if (phase_q == PH_CMD && accept) begin
            blk_q       <= ~cmd_single(rx_q);
            off_q       <= cmd_index(rx_q);
            cmd_valid_q <= 1'b1;
            ptr_q       <= cmd_single(rx_q) ? {1'b0, cmd_index(rx_q)} : '0;
          end
          if (phase_q == PH_WDATA && accept)
            ptr_q <= blk_q ? ptr_q + 1'b1 : PW'(NREG);
        end else if (phase_q == PH_RDATA && bitcnt_q != 4'd0) begin
          tx_q <= {tx_q[6:0], 1'b1};
        end
      end
    end
  end

  assign sda_pull = (in_ack_q & ack_drive_q) |
                    (phase_q == PH_RDATA & ~in_ack_q & ~tx_q[7]);

  // R10
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!cmd_valid_q && phase_q == PH_IDLE));

  // R2
  wr_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cmd_valid_q);
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 8,
  parameter logic [7:0] ID_VALUE    = 8'h18,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NREG*8-1:0] regs_flat;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_xact_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .regs_flat(regs_flat),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  smb_reg_store #(.NREG(NREG), .ID_VALUE(ID_VALUE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign regs_o = regs_flat;
endmodule

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [N*8-1:0] regs;

  int total = 0;
  int bad = 0;
  int own_viol = 0;
  logic [7:0] mdl [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  smb_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  // vector fields: cmd, wdata, expected ack, readback index, expected readback
  localparam logic [32:0] VEC [8] = '{
    {8'h82, 8'h5A, 1'b1, 8'h02, 8'h5A},
    {8'h80, 8'h00, 1'b1, 8'h00, 8'h00},
    {8'h87, 8'h77, 1'b1, 8'h07, 8'h18},
    {8'hA3, 8'h33, 1'b0, 8'h03, 8'h00},
    {8'hC3, 8'h33, 1'b0, 8'h03, 8'h00},
    {8'h88, 8'h99, 1'b0, 8'h01, 8'hFF},
    {8'h86, 8'hC3, 1'b1, 8'h06, 8'hC3},
    {8'h81, 8'h3C, 1'b1, 8'h01, 8'h3C}
  };

  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull != prev_pull && scl_m) own_viol++;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      b[i] = sda_line;
      tick(Q/2);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic read_single(input logic [7:0] idx, output logic [7:0] v, output logic a_rd);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h80 | idx, a);
    bus_restart();
    send_byte(8'hD3, a_rd);
    recv_byte(1'b0, v);
    bus_stop();
  endtask

  task automatic chk_regs(input string req);
    logic [N*8-1:0] e;
    for (int i = 0; i < N; i++) e[i*8 +: 8] = mdl[i];
    chk(req, regs, e);
  endtask

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] v;
    for (int i = 0; i < N; i++) mdl[i] = (i == N-1) ? 8'h18 : (i < 2 ? 8'hFF : 8'h00);

    // R7 reset state
    tick(5);
    chk_regs("R7 reset regs");
    chk("R7 reset pull", sda_pull, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk_regs("R7 after release");

    // R1 foreign address
    bus_start();
    send_byte(8'hD4, a0);
    chk("R1 foreign addr nack", a0, 1'b0);
    send_byte(8'h80, a1);
    chk("R1 foreign addr rest released", a1, 1'b0);
    bus_stop();

    // R2 R3 R4 R8 vector walk
    for (int t = 0; t < 8; t++) begin
      logic [7:0] c, d, ri, ex;
      logic ea;
      {c, d, ea, ri, ex} = VEC[t];
      bus_start();
      send_byte(8'hD2, a0);
      chk("R1 write addr ack", a0, 1'b1);
      send_byte(c, a1);
      chk("R2 cmd ack", a1, ea);
      send_byte(d, a2);
      chk("R3 data ack", a2, ea);
      bus_stop();
      if (ea && c[4:0] != 5'd7) mdl[c[4:0]] = d;
      chk_regs("R2 R3 R8 regs after vector");
      read_single(ri, v, a3);
      chk("R4 read addr ack", a3, 1'b1);
      chk("R4 R8 readback", v, ex);
    end

    // R3 second data byte refused
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h84, a1);
    send_byte(8'h44, a2);
    chk("R3 first data ack", a2, 1'b1);
    send_byte(8'h55, a3);
    chk("R3 second data nack", a3, 1'b0);
    bus_stop();
    mdl[4] = 8'h44;
    chk_regs("R3 regs after extra byte");

    // R5 block write, short
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    send_byte(8'h03, a2);
    chk("R5 count ack", a2, 1'b1);
    send_byte(8'h11, a0);
    send_byte(8'h22, a1);
    send_byte(8'h33, a3);
    chk("R5 data ack", a3, 1'b1);
    bus_stop();
    mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
    chk_regs("R5 regs after block write");

    // R5 R8 block write past the end
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    send_byte(8'h09, a2);
    for (int i = 0; i < 9; i++) begin
      send_byte(8'hA0 + 8'(i), a3);
      if (i == 7) chk("R8 id slot write ack", a3, 1'b1);
      if (i == 8) chk("R5 overrun nack", a3, 1'b0);
    end
    bus_stop();
    for (int i = 0; i < 7; i++) mdl[i] = 8'hA0 + 8'(i);
    chk_regs("R5 R8 regs after overrun");

    // R6 block read
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    bus_restart();
    send_byte(8'hD3, a2);
    chk("R6 read addr ack", a2, 1'b1);
    recv_byte(1'b1, v);
    chk("R6 count byte", v, 8'd8);
    for (int i = 0; i < N; i++) begin
      recv_byte(i != N-1, v);
      chk("R6 block data", v, mdl[i]);
    end
    tick(Q);
    chk("R6 released after nack", sda_pull, 1'b0);
    bus_stop();

    // R9 read with no command
    bus_start();
    send_byte(8'hD3, a0);
    chk("R9 bare read nack", a0, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h82, a1);
    bus_stop();
    bus_start();
    send_byte(8'hD3, a2);
    chk("R9 read after stop nack", a2, 1'b0);
    bus_stop();

    chk("R10 pull changes only with SCL low", own_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule